// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog reached through a small synchronous register bus. Software programs a 16-bit reload period, an expiry action (a reset request or an interrupt), an optional clock divider and a debug-freeze permission in one control word. Once enabled, a down-counter runs from the reload period toward zero. Software keeps the system alive by writing two fixed key values, in order, to a service halfword. If the counter reaches zero first, the block raises its expiry action.

The control word can be committed exactly once after power-on reset. Every later control write is dropped, so runaway code cannot switch the watchdog off or stretch its period. A sticky flag remembers that the watchdog asked for a reset, and it survives until software clears it by writing 1.

Bus accesses are word-aligned. An access whose two low address bits are not zero is ignored and reads as zero. The service halfword sits in the upper two byte lanes of the word at 0xC. A service write counts only if both upper byte strobes are set.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control word (0x4) reads 0xFFFF0003 with bit 2 equal to the START_ENABLED parameter. The count (0x8) reads 0x0000FFFF and does not move while disabled. Offsets 0x0, 0xC and 0x10 read zero, and both request outputs are low.
- R2: The control word layout is: bits 31:16 reload period, bit 3 freeze permission, bit 2 enable, bit 1 expiry action (1 = reset, 0 = interrupt), bit 0 divider enable; bits 15:4 read zero. The first control write with any strobe set merges only its strobed byte lanes into the word.
- R3: After that first write the control word is locked until power-on reset, and further writes leave its read-back value unchanged.
- R4: Writing 0x556C and then 0xAA39 to the service halfword (bits 31:16 at 0xC) reloads the counter from the reload period on the edge of the second write.
- R5: Any other service value, or 0xAA39 without a preceding 0x556C, disarms the key checker without a reload. A repeated 0x556C keeps the checker armed.
- R6: With the divider off, the counter drops by one on every clock, and the value can be read at 0x8.
- R7: With the divider on, the counter drops by one every 2^PRESC_LOG2 clocks, counted from the last reload.
- R8: In reset mode, the clock edge that takes the count from 1 to 0 raises `wd_rst_req` for exactly one cycle, and the counter then stays at zero. One cycle later, bit 0 at 0x10 becomes 1 and stays set until a write of 1 to that bit; writing 0 leaves it set.
- R9: In interrupt mode, reaching zero sets `wd_irq` as a level and reloads the counter, which keeps running. A completed key pair clears `wd_irq`.
- R10: When the freeze bit is set and `dbg_halt` is high, the counter and divider hold their values. When the freeze bit is clear, `dbg_halt` has no effect.
- R11: A reload period of zero loads 0x10000 (65536) into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (word-aligned) |
| bus_strb | input | 4 | Byte-lane write strobes; lane i covers bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| dbg_halt | input | 1 | Debug halt; freezes the watchdog when permitted |
| wd_rst_req | output | 1 | One-cycle reset request on expiry |
| wd_irq | output | 1 | Level interrupt on expiry |

## Verification
Several service write patterns are driven: the correct pair, a lone second key, a first key followed by a foreign value, and a doubled first key. Together they separate a checker that tracks order from one that only matches values, and one that disarms on a repeated arm from one that stays armed. Expiry is driven in both action modes, so that a pulse with a held count can be told apart from a level with a reload. Counting is sampled with the divider on and off and with `dbg_halt` under both settings of the freeze bit. A partial-strobe first write followed by a full second write shows byte merging and the lock in the same read-back.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int TC_W  = 16;
    localparam int CNT_W = TC_W + 1;

    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    localparam int WORD_CTRL = 1;
    localparam int WORD_CNT  = 2;
    localparam int WORD_SVC  = 3;
    localparam int WORD_STAT = 4;

    typedef struct packed {
        logic [TC_W-1:0] tc;
        logic            frz;
        logic            en;
        logic            rsel;
        logic            pre;
    } ctrl_t;

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        return {c.tc, 12'd0, c.frz, c.en, c.rsel, c.pre};
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.tc   = w[31:16];
        c.frz  = w[3];
        c.en   = w[2];
        c.rsel = w[1];
        c.pre  = w[0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] reload_of(input logic [TC_W-1:0] tc);
        return (tc == '0) ? {1'b1, {TC_W{1'b0}}} : {1'b0, tc};
    endfunction
endpackage

// File: rtl/kwdt_keychk.sv
module kwdt_keychk
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_val,
    output logic        kick
);
    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        kick = 1'b0;
        if (svc_wr) begin
            if (svc_val == KEY_ARM) begin
                st_d.armed = 1'b1;
            end else begin
                st_d.armed = 1'b0;
                if (svc_val == KEY_FIRE && st_q.armed) begin
                    kick = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a first key always leaves the checker armed
    assert_arm_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_val == KEY_ARM) |=> st_q.armed);
    // R4: a completed pair returns the checker to idle
    assert_kick_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !st_q.armed);
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic wrap
);
    typedef struct packed {
        logic [LOG2-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.div == '1);
        if (clear)    st_d.div = '0;
        else if (run) st_d.div = st_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: the divider holds while stopped
    assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(st_q.div));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_CNT = {1'b0, {TC_W{1'b1}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             rsel,
    input  logic             kick,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst_req;
        logic             irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    expire;

    always_comb begin
        st_d   = st_q;
        expire = tick && !load && (st_q.cnt == CNT_W'(1));
        st_d.rst_req = expire && rsel;
        if (kick)                 st_d.irq = 1'b0;
        else if (expire && !rsel) st_d.irq = 1'b1;
        if (load)                         st_d.cnt = load_val;
        else if (expire && !rsel)         st_d.cnt = load_val;
        else if (tick && st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= RST_CNT;
            st_q.rst_req <= 1'b0;
            st_q.irq     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign rst_req = st_q.rst_req;
    assign irq     = st_q.irq;

    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> !st_q.rst_req);
    assert_cnt_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= {1'b1, {TC_W{1'b0}}});
    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !kick) |=> st_q.irq);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int PRESC_LOG2    = 16,
    parameter int START_ENABLED = 0,
    parameter int ADDR_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_strb,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dbg_halt,
    output logic              wd_rst_req,
    output logic              wd_irq
);
    localparam int    WORD_W   = ADDR_W - 2;
    localparam ctrl_t CTRL_RST = ctrl_t'({16'hFFFF, 1'b0, 1'(START_ENABLED), 1'b1, 1'b1});

    typedef struct packed {
        ctrl_t ctrl;
        logic  locked;
        logic  flag;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [WORD_W-1:0] word;
    logic              acc, wr, ctrl_wr, commit, svc_wr, kick;
    logic              hold, run_div, wrap, tick, load;
    logic [31:0]       merged;
    logic [CNT_W-1:0]  load_val, cnt;

    always_comb begin
        word    = bus_addr[ADDR_W-1:2];
        acc     = bus_sel && (bus_addr[1:0] == 2'b00);
        wr      = acc && bus_wr;
        ctrl_wr = wr && (word == WORD_W'(WORD_CTRL)) && (|bus_strb);
        commit  = ctrl_wr && !st_q.locked;
        svc_wr  = wr && (word == WORD_W'(WORD_SVC)) && (&bus_strb[3:2]);

        merged = ctrl_to_word(st_q.ctrl);
        for (int i = 0; i < 4; i++) begin
            if (bus_strb[i]) merged[8*i +: 8] = bus_wdata[8*i +: 8];
        end

        st_d = st_q;
        if (commit) begin
            st_d.ctrl   = word_to_ctrl(merged);
            st_d.locked = 1'b1;
        end
        if (wr && (word == WORD_W'(WORD_STAT)) && bus_strb[0] && bus_wdata[0]) st_d.flag = 1'b0;
        if (wd_rst_req) st_d.flag = 1'b1;

        hold     = st_d.ctrl.frz && dbg_halt;
        run_div  = st_d.ctrl.en && st_d.ctrl.pre && !hold;
        tick     = st_d.ctrl.en && !hold && (st_d.ctrl.pre ? wrap : 1'b1);
        load     = commit || kick || !st_d.ctrl.en;
        load_val = reload_of(st_d.ctrl.tc);

        bus_rdata = '0;
        if (acc) begin
            if (word == WORD_W'(WORD_CTRL))      bus_rdata = ctrl_to_word(st_q.ctrl);
            else if (word == WORD_W'(WORD_CNT))  bus_rdata = {{(32-CNT_W){1'b0}}, cnt};
            else if (word == WORD_W'(WORD_STAT)) bus_rdata = {31'd0, st_q.flag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl   <= CTRL_RST;
            st_q.locked <= 1'b0;
            st_q.flag   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    kwdt_keychk u_keychk (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_wr  (svc_wr),
        .svc_val (bus_wdata[31:16]),
        .kick    (kick)
    );

    kwdt_prescale #(.LOG2(PRESC_LOG2)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .run   (run_div),
        .wrap  (wrap)
    );

    kwdt_counter #(.RST_CNT(reload_of(CTRL_RST.tc))) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .tick     (tick),
        .rsel     (st_d.ctrl.rsel),
        .kick     (kick),
        .cnt      (cnt),
        .rst_req  (wd_rst_req),
        .irq      (wd_irq)
    );

    assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.ctrl));
    assert_first_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> st_q.locked);
    assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == $past(load_val)));
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load) |=> $stable(cnt));
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> st_q.flag);
endmodule

// File: tb/kwdt_top_bench.sv
`timescale 1ns/100ps
module kwdt_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        wd_rst_req;
    logic        wd_irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    kwdt_top #(.PRESC_LOG2(4), .START_ENABLED(0), .ADDR_W(5)) u_kwdt_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .wd_rst_req(wd_rst_req), .wd_irq(wd_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic por();
        dbg_halt = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_strb = s; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_strb = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic svc(input logic [15:0] v);
        wr(5'h0C, 4'b1100, {v, 16'h0000});
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        por();
        rd(5'h04, v); chk("R1 ctrl reset", v, 32'hFFFF0003);
        rd(5'h08, v); chk("R1 count reset", v, 32'h0000FFFF);
        rd(5'h00, v); chk("R1 offset 0 reads zero", v, 32'h0);
        rd(5'h0C, v); chk("R1 offset C reads zero", v, 32'h0);
        rd(5'h10, v); chk("R1 status reset", v, 32'h0);
        chk("R1 rst_req low", {31'd0, wd_rst_req}, 32'h0);
        chk("R1 irq low", {31'd0, wd_irq}, 32'h0);
        cyc(5);
        rd(5'h08, v); chk("R1 disabled count holds", v, 32'h0000FFFF);
    endtask

    task automatic t_strobe_lock();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b0001, 32'h0014_0006);
        rd(5'h04, v); chk("R2 byte-lane merge", v, 32'hFFFF0006);
        wr(5'h04, 4'b1111, 32'h0032_0001);
        rd(5'h04, v); chk("R3 locked after first write", v, 32'hFFFF0006);
    endtask

    task automatic t_count_keys();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b1111, 32'h0028_0006);
        rd(5'h08, v); chk("R6 loaded on commit", v, 32'd40);
        cyc(7);
        rd(5'h08, v); chk("R6 decrement per clock", v, 32'd33);
        svc(16'h556C);
        svc(16'hAA39);
        rd(5'h08, v); chk("R4 key pair reloads", v, 32'd40);
        cyc(10);
        svc(16'hAA39);
        rd(5'h08, v); chk("R5 lone second key ignored", v, 32'd29);
        svc(16'h556C); svc(16'h1234); svc(16'hAA39);
        rd(5'h08, v); chk("R5 foreign value disarms", v, 32'd26);
        svc(16'h556C); svc(16'h556C); svc(16'hAA39);
        rd(5'h08, v); chk("R5 repeated first key stays armed", v, 32'd40);
    endtask

    task automatic t_expire_reset();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b1111, 32'h000C_0006);
        cyc(11);
        rd(5'h08, v); chk("R8 count before expiry", v, 32'd1);
        chk("R8 no request yet", {31'd0, wd_rst_req}, 32'h0);
        cyc(1);
        chk("R8 request raised", {31'd0, wd_rst_req}, 32'h1);
        rd(5'h08, v); chk("R8 count at zero", v, 32'd0);
        cyc(1);
        chk("R8 request one cycle", {31'd0, wd_rst_req}, 32'h0);
        rd(5'h08, v); chk("R8 count holds zero", v, 32'd0);
        rd(5'h10, v); chk("R8 sticky flag set", v, 32'h1);
        chk("R8 no irq in reset mode", {31'd0, wd_irq}, 32'h0);
        wr(5'h10, 4'b0001, 32'h0);
        rd(5'h10, v); chk("R8 write 0 keeps flag", v, 32'h1);
        wr(5'h10, 4'b0001, 32'h1);
        rd(5'h10, v); chk("R8 write 1 clears flag", v, 32'h0);
    endtask

    task automatic t_expire_irq();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b1111, 32'h000A_0004);
        cyc(9);
        chk("R9 irq low before expiry", {31'd0, wd_irq}, 32'h0);
        cyc(1);
        chk("R9 irq raised", {31'd0, wd_irq}, 32'h1);
        chk("R9 no reset request", {31'd0, wd_rst_req}, 32'h0);
        rd(5'h08, v); chk("R9 reload on expiry", v, 32'd10);
        cyc(3);
        chk("R9 irq is a level", {31'd0, wd_irq}, 32'h1);
        rd(5'h08, v); chk("R9 keeps running", v, 32'd7);
        svc(16'h556C); svc(16'hAA39);
        chk("R9 service clears irq", {31'd0, wd_irq}, 32'h0);
        rd(5'h10, v); chk("R9 no sticky flag", v, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b1111, 32'h0005_0005);
        cyc(15);
        rd(5'h08, v); chk("R7 holds within divide window", v, 32'd5);
        cyc(1);
        rd(5'h08, v); chk("R7 first divided step", v, 32'd4);
        cyc(16);
        rd(5'h08, v); chk("R7 second divided step", v, 32'd3);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b1111, 32'h0064_000E);
        cyc(5);
        rd(5'h08, v); chk("R10 running before halt", v, 32'd95);
        dbg_halt = 1'b1;
        cyc(10);
        rd(5'h08, v); chk("R10 frozen during halt", v, 32'd95);
        dbg_halt = 1'b0;
        cyc(3);
        rd(5'h08, v); chk("R10 resumes after halt", v, 32'd92);
        por();
        wr(5'h04, 4'b1111, 32'h0064_0006);
        cyc(5);
        dbg_halt = 1'b1;
        cyc(10);
        rd(5'h08, v); chk("R10 halt ignored without freeze bit", v, 32'd85);
        dbg_halt = 1'b0;
    endtask

    task automatic t_zero_period();
        logic [31:0] v;
        por();
        wr(5'h04, 4'b1111, 32'h0000_0006);
        rd(5'h08, v); chk("R11 zero period loads 65536", v, 32'h0001_0000);
        cyc(1);
        rd(5'h08, v); chk("R11 counts down from 65536", v, 32'h0000_FFFF);
    endtask

    initial begin
        t_reset();
        t_strobe_lock();
        t_count_keys();
        t_expire_reset();
        t_expire_irq();
        t_prescale();
        t_freeze();
        t_zero_period();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule